// File: doc/BRIEF.md
# Banked VGA Register Decoder

This block is the byte-wide I/O register file of a VGA-compatible display controller that supports extended banking. A host drives single-byte reads and writes on a legacy I/O port bus. The block decodes the miscellaneous-output, sequencer index/data and CRTC index/data ports. It keeps the CRTC and sequencer register bytes and derives the frame-buffer bank state from them.

The bank number is 7 bits wide and is built from three extended CRTC registers. One register sets the low nibble. A second sets bits 5:4 and also feeds the extended display start-address field. A third loads the whole bank. The sequencer chain-4 flag selects the bank granule, 64 KiB or 16 KiB. The block drives the read and write bank base addresses continuously. A fixed chip identifier can be read through the CRTC data port.

Bit 0 of the miscellaneous-output register selects the monochrome or colour port map. When it is clear, addresses in the 0x3Bx and 0x3Dx ranges are XORed with 0x60 before decoding. At reset the CRTC therefore answers at 0x3B4/0x3B5.

Top module: `vga_bank_regs`

## Requirements
- R1: After reset, both bank base outputs and the extended start field are zero, and a read of the CRTC index port returns 0x00.
- R2: A write to the CRTC index port stores data bits 6:0 only, and bit 7 is dropped. A read of that port returns the stored index.
- R3: A write to CRTC register 0x35 sets bank bits 3:0 from data bits 3:0 and leaves bank bits 6:4 unchanged.
- R4: A write to CRTC register 0x51 sets bank bits 5:4 from data bits 3:2 and leaves bank bits 6 and 3:0 unchanged. The same write sets bits 3:2 of the 4-bit extended start field from data bits 1:0. Bits 1:0 of that field stay zero.
- R5: A write to CRTC register 0x6A loads all 7 bank bits from data bits 6:0.
- R6: The read and write bank bases are equal. Each is the bank shifted left by 16 when chain-4 is set, and shifted left by 14 when it is clear.
- R7: A write to sequencer data port 0x3C5 while the sequencer index (port 0x3C4, low 3 bits) is 4 takes chain-4 from data bit 3. Both bases show the new scaling in the cycle after the write.
- R8: A read of the CRTC data port while the index is 0x2D returns 0x88, whatever was written there.
- R9: The miscellaneous register is written at 0x3C2 and read at 0x3CC. While its bit 0 is 0, ports 0x3Bx are remapped to 0x3Dx and 0x3Dx to 0x3Bx, so a write at 0x3D4 is ignored. While bit 0 is 1, the CRTC is decoded directly at 0x3D4/0x3D5, and 0x3B4 is unrecognised and reads 0x00.
- R10: A read of the CRTC data port at any index other than 0x2D returns the last byte written to that index. A write to an index other than 0x35, 0x51 or 0x6A leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| rd_valid | output | 1 | io_rdata holds the result of a read |
| rd_bank_base | output | 23 | Read bank base address |
| wr_bank_base | output | 23 | Write bank base address |
| start_ext | output | 4 | Extended display start-address field |

## Verification
A write takes effect at the clock edge where it is sampled. The bank bases and the start field are combinational from the registers, so they are checked half a cycle after that edge. With the default registered read path, read data and rd_valid appear one edge after the read strobe. The driver queues each expected byte when it issues the read. A monitor pops the queue at every falling edge where rd_valid is high, so each comparison lands in the exact cycle the result is due.

// File: rtl/vga_bank_pkg.sv
package vga_bank_pkg;
   localparam logic [15:0] PORT_MISC_WR  = 16'h03C2;
   localparam logic [15:0] PORT_MISC_RD  = 16'h03CC;
   localparam logic [15:0] PORT_SEQ_IDX  = 16'h03C4;
   localparam logic [15:0] PORT_SEQ_DAT  = 16'h03C5;
   localparam logic [15:0] PORT_CRTC_IDX = 16'h03D4;
   localparam logic [15:0] PORT_CRTC_DAT = 16'h03D5;
   localparam logic [15:0] REMAP_XOR     = 16'h0060;

   localparam logic [6:0] CR_BANK_LO   = 7'h35;
   localparam logic [6:0] CR_BANK_MID  = 7'h51;
   localparam logic [6:0] CR_BANK_FULL = 7'h6A;
   localparam logic [6:0] CR_CHIP_ID   = 7'h2D;
   localparam logic [7:0] CHIP_ID_VALUE = 8'h88;
   localparam logic [2:0] SR_MEM_MODE  = 3'd4;
   localparam int         CHAIN4_BIT   = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MISC_WR,
      SEL_MISC_RD,
      SEL_SEQ_IDX,
      SEL_SEQ_DAT,
      SEL_CRTC_IDX,
      SEL_CRTC_DAT
   } port_sel_e;
endpackage

// File: rtl/vga_port_decode.sv
module vga_port_decode
   import vga_bank_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mono_remap,
   output port_sel_e         sel
);
   localparam int HI_W = ADDR_W - 4;

   initial begin
      if (ADDR_W < 10) $error("ADDR_W too small for VGA port space");
   end

   logic [ADDR_W-1:0] eff;
   logic              in_mono, in_color;

   always_comb begin
      in_mono  = addr[ADDR_W-1:4] == HI_W'(12'h03B);
      in_color = addr[ADDR_W-1:4] == HI_W'(12'h03D);
      eff = addr;
      if (mono_remap && (in_mono || in_color))
         eff = addr ^ ADDR_W'(REMAP_XOR);
   end

   always_comb begin
      sel = SEL_NONE;
      if      (eff == ADDR_W'(PORT_MISC_WR))  sel = SEL_MISC_WR;
      else if (eff == ADDR_W'(PORT_MISC_RD))  sel = SEL_MISC_RD;
      else if (eff == ADDR_W'(PORT_SEQ_IDX))  sel = SEL_SEQ_IDX;
      else if (eff == ADDR_W'(PORT_SEQ_DAT))  sel = SEL_SEQ_DAT;
      else if (eff == ADDR_W'(PORT_CRTC_IDX)) sel = SEL_CRTC_IDX;
      else if (eff == ADDR_W'(PORT_CRTC_DAT)) sel = SEL_CRTC_DAT;
   end
endmodule

// File: rtl/vga_seq_file.sv
module vga_seq_file
   import vga_bank_pkg::*;
#(
   parameter int SEQ_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idx_wr,
   input  logic                 dat_wr,
   input  logic [7:0]           wdata,
   output logic [SEQ_IDX_W-1:0] seq_idx,
   output logic [7:0]           rd_byte,
   output logic                 chain4
);
   localparam int DEPTH = 1 << SEQ_IDX_W;

   initial begin
      if (SEQ_IDX_W < 3 || SEQ_IDX_W > 8) $error("SEQ_IDX_W out of range");
   end

   logic [7:0] regs [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_idx <= '0;
         chain4  <= 1'b0;
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else begin
         if (idx_wr) seq_idx <= wdata[SEQ_IDX_W-1:0];
         if (dat_wr) begin
            regs[seq_idx] <= wdata;
            if (seq_idx == SEQ_IDX_W'(SR_MEM_MODE))
               chain4 <= wdata[CHAIN4_BIT];
         end
      end
   end

   assign rd_byte = regs[seq_idx];

   // R7: chain-4 follows data bit 3 of a memory-mode write
   p_chain4_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && seq_idx == SEQ_IDX_W'(SR_MEM_MODE)) |=> chain4 == $past(wdata[CHAIN4_BIT]));
endmodule

// File: rtl/vga_crtc_file.sv
module vga_crtc_file
   import vga_bank_pkg::*;
#(
   parameter int IDX_W  = 7,
   parameter int BANK_W = 7,
   parameter int EXT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic [7:0]        wdata,
   output logic [IDX_W-1:0]  crtc_idx,
   output logic [7:0]        rd_byte,
   output logic [BANK_W-1:0] bank,
   output logic [EXT_W-1:0]  start_ext
);
   localparam int DEPTH = 1 << IDX_W;

   initial begin
      if (IDX_W != 7) $error("CRTC index must be 7 bits");
      if (BANK_W < 7 || BANK_W > 8) $error("BANK_W must be 7 or 8");
      if (EXT_W < 4) $error("EXT_W must be at least 4");
   end

   logic [7:0] regs [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crtc_idx  <= '0;
         bank      <= '0;
         start_ext <= '0;
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else begin
         if (idx_wr) crtc_idx <= wdata[IDX_W-1:0];
         if (dat_wr) begin
            regs[crtc_idx] <= wdata;
            if (crtc_idx == IDX_W'(CR_BANK_LO)) begin
               bank[3:0] <= wdata[3:0];
            end else if (crtc_idx == IDX_W'(CR_BANK_MID)) begin
               bank[5:4]      <= wdata[3:2];
               start_ext[3:2] <= wdata[1:0];
            end else if (crtc_idx == IDX_W'(CR_BANK_FULL)) begin
               bank <= BANK_W'(wdata);
            end
         end
      end
   end

   assign rd_byte = regs[crtc_idx];

   p_idx_low7_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> crtc_idx == $past(wdata[IDX_W-1:0]));

   p_bank_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && crtc_idx == IDX_W'(CR_BANK_LO)) |=>
         (bank[3:0] == $past(wdata[3:0]) && bank[6:4] == $past(bank[6:4])));

   p_bank_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && crtc_idx == IDX_W'(CR_BANK_MID)) |=>
         (bank[5:4] == $past(wdata[3:2]) && bank[6] == $past(bank[6]) &&
          bank[3:0] == $past(bank[3:0]) && start_ext[3:2] == $past(wdata[1:0])));

   p_bank_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && crtc_idx == IDX_W'(CR_BANK_FULL)) |=> bank[6:0] == $past(wdata[6:0]));

   p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && crtc_idx != IDX_W'(CR_BANK_LO) && crtc_idx != IDX_W'(CR_BANK_MID) &&
       crtc_idx != IDX_W'(CR_BANK_FULL)) |=> $stable(bank));
endmodule

// File: rtl/vga_bank_scaler.sv
module vga_bank_scaler #(
   parameter int BANK_W   = 7,
   parameter int HI_SHIFT = 16,
   parameter int LO_SHIFT = 14
) (
   input  logic                       chain4,
   input  logic [BANK_W-1:0]          bank,
   output logic [BANK_W+HI_SHIFT-1:0] base
);
   localparam int BASE_W = BANK_W + HI_SHIFT;

   initial begin
      if (HI_SHIFT <= LO_SHIFT) $error("HI_SHIFT must exceed LO_SHIFT");
   end

   always_comb begin
      if (chain4) base = {bank, {HI_SHIFT{1'b0}}};
      else        base = BASE_W'({bank, {LO_SHIFT{1'b0}}});
   end
endmodule

// File: rtl/vga_bank_regs.sv
module vga_bank_regs
   import vga_bank_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int IDX_W     = 7,
   parameter int SEQ_IDX_W = 3,
   parameter int BANK_W    = 7,
   parameter int HI_SHIFT  = 16,
   parameter int LO_SHIFT  = 14,
   parameter int EXT_W     = 4,
   parameter bit REG_READ  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       io_wr,
   input  logic                       io_rd,
   input  logic [ADDR_W-1:0]          io_addr,
   input  logic [7:0]                 io_wdata,
   output logic [7:0]                 io_rdata,
   output logic                       rd_valid,
   output logic [BANK_W+HI_SHIFT-1:0] rd_bank_base,
   output logic [BANK_W+HI_SHIFT-1:0] wr_bank_base,
   output logic [EXT_W-1:0]           start_ext
);
   localparam int BASE_W = BANK_W + HI_SHIFT;

   port_sel_e            sel;
   logic [7:0]           misc;
   logic [IDX_W-1:0]     crtc_idx;
   logic [7:0]           crtc_byte, seq_byte;
   logic [SEQ_IDX_W-1:0] seq_idx;
   logic                 chain4;
   logic [BANK_W-1:0]    bank;
   logic [BASE_W-1:0]    base;
   logic [7:0]           rd_mux;

   vga_port_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr(io_addr), .mono_remap(~misc[0]), .sel(sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                           misc <= '0;
      else if (io_wr && sel == SEL_MISC_WR) misc <= io_wdata;
   end

   vga_seq_file #(.SEQ_IDX_W(SEQ_IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(io_wr && sel == SEL_SEQ_IDX),
      .dat_wr(io_wr && sel == SEL_SEQ_DAT),
      .wdata(io_wdata), .seq_idx(seq_idx), .rd_byte(seq_byte), .chain4(chain4)
   );

   vga_crtc_file #(.IDX_W(IDX_W), .BANK_W(BANK_W), .EXT_W(EXT_W)) u_crtc (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(io_wr && sel == SEL_CRTC_IDX),
      .dat_wr(io_wr && sel == SEL_CRTC_DAT),
      .wdata(io_wdata), .crtc_idx(crtc_idx), .rd_byte(crtc_byte),
      .bank(bank), .start_ext(start_ext)
   );

   vga_bank_scaler #(.BANK_W(BANK_W), .HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)) u_scale (
      .chain4(chain4), .bank(bank), .base(base)
   );

   assign rd_bank_base = base;
   assign wr_bank_base = base;

   always_comb begin
      case (sel)
         SEL_MISC_RD:  rd_mux = misc;
         SEL_SEQ_IDX:  rd_mux = 8'(seq_idx);
         SEL_SEQ_DAT:  rd_mux = seq_byte;
         SEL_CRTC_IDX: rd_mux = 8'(crtc_idx);
         SEL_CRTC_DAT: rd_mux = (crtc_idx == IDX_W'(CR_CHIP_ID)) ? CHIP_ID_VALUE : crtc_byte;
         default:      rd_mux = 8'h00;
      endcase
   end

   generate
      if (REG_READ) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               io_rdata <= '0;
               rd_valid <= 1'b0;
            end else begin
               io_rdata <= io_rd ? rd_mux : 8'h00;
               rd_valid <= io_rd;
            end
         end

         p_chip_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (io_rd && sel == SEL_CRTC_DAT && crtc_idx == IDX_W'(CR_CHIP_ID)) |=>
               (rd_valid && io_rdata == CHIP_ID_VALUE));
      end else begin : g_rd_comb
         assign io_rdata = io_rd ? rd_mux : 8'h00;
         assign rd_valid = io_rd;
      end
   endgenerate

   // R9: with the mono map active, a write at the colour CRTC index port is ignored
   p_remap_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !misc[0] && io_addr == ADDR_W'(PORT_CRTC_IDX)) |=> $stable(crtc_idx));

   // R6: the bank granule follows chain-4
   p_granule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chain4 |-> rd_bank_base[HI_SHIFT-1:0] == '0);
endmodule

// File: tb/vga_bank_regs_bench.sv
module vga_bank_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        rd_valid;
   logic [22:0] rd_bank_base, wr_bank_base;
   logic [3:0]  start_ext;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vga_bank_regs u_vga_bank_regs (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .rd_valid(rd_valid),
      .rd_bank_base(rd_bank_base), .wr_bank_base(wr_bank_base), .start_ext(start_ext)
   );

   task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic check_bases(logic [6:0] bank, bit ch4, string tag);
      logic [22:0] exp;
      exp = ch4 ? {bank, 16'h0} : 23'({bank, 14'h0});
      check_val({tag, " rd base"}, 32'(rd_bank_base), 32'(exp));
      check_val({tag, " wr base"}, 32'(wr_bank_base), 32'(exp));
   endtask

   // monitor: compare read results in the cycle they are due
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL read: unexpected result actual %0h expected none", io_rdata);
         end else begin
            check_val(tag_q.pop_front(), 32'(io_rdata), 32'(exp_q.pop_front()));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_bases(7'h00, 1'b0, "R1");
      check_val("R1 start_ext", 32'(start_ext), 0);
      rd(16'h03B4, 8'h00, "R1 crtc index");

      // R2 index keeps bits 6:0
      wr(16'h03B4, 8'hB5);
      rd(16'h03B4, 8'h35, "R2 index low7");

      // R5 full bank load; R10 stored byte readback
      wr(16'h03B4, 8'h6A);
      wr(16'h03B5, 8'hDA);
      check_bases(7'h5A, 1'b0, "R5");
      rd(16'h03B5, 8'hDA, "R10 readback 0x6A");

      // R3 low nibble
      wr(16'h03B4, 8'h35);
      wr(16'h03B5, 8'hF7);
      check_bases(7'h57, 1'b0, "R3");

      // R4 bits 5:4 and start field
      wr(16'h03B4, 8'h51);
      wr(16'h03B5, 8'h0E);
      check_bases(7'h77, 1'b0, "R4 set");
      check_val("R4 start_ext", 32'(start_ext), 32'h8);

      // R7 / R6 chain-4 scaling
      wr(16'h03C4, 8'h04);
      wr(16'h03C5, 8'h08);
      check_bases(7'h77, 1'b1, "R7 chain4 on");
      rd(16'h03C5, 8'h08, "R7 seq readback");
      wr(16'h03C5, 8'h00);
      check_bases(7'h77, 1'b0, "R6 chain4 off");

      // R4 clearing bits 5:4
      wr(16'h03B4, 8'h51);
      wr(16'h03B5, 8'h03);
      check_bases(7'h47, 1'b0, "R4 clear");
      check_val("R4 start_ext 2", 32'(start_ext), 32'hC);

      // R8 chip id, even after a write
      wr(16'h03B4, 8'h2D);
      rd(16'h03B5, 8'h88, "R8 chip id");
      wr(16'h03B5, 8'h12);
      rd(16'h03B5, 8'h88, "R8 chip id after write");
      check_bases(7'h47, 1'b0, "R10 bank hold");

      // R9 remap: colour index port ignored while mono
      wr(16'h03D4, 8'h10);
      rd(16'h03B4, 8'h2D, "R9 ignored write");
      wr(16'h03C2, 8'h01);
      rd(16'h03CC, 8'h01, "R9 misc readback");
      wr(16'h03D4, 8'h20);
      rd(16'h03D4, 8'h20, "R9 colour index");
      rd(16'h03B4, 8'h00, "R9 mono unmapped");

      // R10 plain register at colour data port
      wr(16'h03D5, 8'hC3);
      rd(16'h03D5, 8'hC3, "R10 plain reg");
      check_bases(7'h47, 1'b0, "R10 bank untouched");

      repeat (3) @(negedge clk);
      check_val("queue drained", 32'(exp_q.size()), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule